// File: doc/BRIEF.md
# 24-bit Floating-Point Multiplier

This block multiplies two raw 24-bit floating-point words and returns a raw 24-bit product one clock later. The format holds a sign, a 7-bit biased exponent (bias 63) and a 16-bit fraction with an implied leading one. Denormals are not supported.

It is meant for a shader datapath that relies on one non-IEEE rule: a zero operand forces a zero result, even when the other operand is infinite. NaN still wins over that rule.

The multiply is a single combinational path that ends in one register. That register also carries a valid flag, which is the only handshake.

Top module: `fp24_mul`

## Requirements
- R1: Bit 23 holds the sign, bits 22:16 the exponent and bits 15:0 the fraction. Only the all-zero word is zero. Any other word with an exponent below 0x7F has the value (-1)^sign × 2^(exp−63) × (1 + frac/65536), so 0x800000 is −2^−63.
- R2: If one operand is zero and the other is a finite number, the product is +0 (0x000000), whatever the sign of the other operand.
- R3: Zero times infinity, in either operand order and with either sign of infinity, gives +0 (0x000000).
- R4: Exponent 0x7F with a nonzero fraction is NaN. A NaN operand, including NaN times zero, gives the canonical NaN 0x7F8000, and no other NaN pattern ever appears at the output.
- R5: Exponent 0x7F with a zero fraction is infinity. Infinity times a nonzero non-NaN operand gives infinity (0x7F0000 or 0xFF0000), and its sign is the XOR of the operand signs.
- R6: For two finite nonzero operands, the product sign is the XOR of the operand signs, and the exponent and fraction are those of the normalised exact product.
- R7: The 16-bit product fraction is rounded to nearest, with ties going to even. A round-up that carries out of the fraction raises the exponent by one.
- R8: A rounded result exponent above 0x7E gives infinity with the product sign.
- R9: A rounded result exponent below 0 flushes to +0 (0x000000).
- R10: out_valid equals in_valid from the previous cycle. out_prod loads only on cycles where in_valid is high and holds otherwise. Reset clears both outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands on in_a/in_b are valid this cycle |
| in_a | input | 24 | First operand, raw word |
| in_b | input | 24 | Second operand, raw word |
| out_valid | output | 1 | out_prod holds a new product |
| out_prod | output | 24 | Registered product, raw word |

## Verification
The assertions assume nothing about which operand patterns appear. They hold for any 24-bit word, including NaN fractions and the sign-only word 0x800000. They do assume that in_valid is known in every cycle after reset, because the latency and hold checks sample it every cycle.

The random stimulus draws every operand class, so zeros, infinities, NaNs and finite values all reach the special-case properties. It also draws exponents across the full range, which exercises both overflow and underflow. Directed pairs then cover rounding ties, the rounding carry and the exact format limits.

// File: rtl/fp24_pkg.sv
package fp24_pkg;
    // Operand classification shared by unpacker and top
    typedef enum logic [1:0] {
        CLS_ZERO = 2'd0,
        CLS_NORM = 2'd1,
        CLS_INF  = 2'd2,
        CLS_NAN  = 2'd3
    } fp_class_e;
endpackage

// File: rtl/fp24_unpack.sv
module fp24_unpack
    import fp24_pkg::*;
#(
    parameter int EXP_W = 7,
    parameter int MAN_W = 16,
    localparam int W    = 1 + EXP_W + MAN_W
) (
    input  logic [W-1:0]     word_i,
    output fp_class_e        cls_o,
    output logic             sign_o,
    output logic [EXP_W-1:0] exp_o,
    output logic [MAN_W-1:0] man_o
);
    assign sign_o = word_i[W-1];
    assign exp_o  = word_i[W-2 -: EXP_W];
    assign man_o  = word_i[MAN_W-1:0];

    always_comb begin
        if (word_i == '0) begin
            cls_o = CLS_ZERO;
        end else if (&exp_o) begin
            cls_o = (man_o == '0) ? CLS_INF : CLS_NAN;
        end else begin
            cls_o = CLS_NORM;
        end
    end
endmodule

// File: rtl/fp24_sigmul.sv
module fp24_sigmul #(
    parameter int EXP_W = 7,
    parameter int MAN_W = 16,
    parameter int BIAS  = (1 << (EXP_W - 1)) - 1,
    localparam int SIG_W  = MAN_W + 1,
    localparam int PROD_W = 2 * SIG_W,
    localparam int XW     = EXP_W + 3
) (
    input  logic [EXP_W-1:0]      exp_a_i,
    input  logic [EXP_W-1:0]      exp_b_i,
    input  logic [MAN_W-1:0]      man_a_i,
    input  logic [MAN_W-1:0]      man_b_i,
    output logic signed [XW-1:0]  exp_o,
    output logic [MAN_W-1:0]      man_o
);
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] norm;
    logic              top;
    logic [MAN_W-1:0]  kept;
    logic              guard;
    logic              sticky;
    logic              round_up;
    logic [MAN_W:0]    sum;
    logic              carry;

    always_comb begin
        prod     = PROD_W'({1'b1, man_a_i}) * PROD_W'({1'b1, man_b_i});
        top      = prod[PROD_W-1];
        // Bring the leading one to bit PROD_W-1
        norm     = top ? prod : (prod << 1);
        kept     = norm[PROD_W-2 -: MAN_W];
        guard    = norm[PROD_W-2-MAN_W];
        sticky   = |norm[PROD_W-3-MAN_W:0];
        // Nearest, ties to even
        round_up = guard & (sticky | kept[0]);
        sum      = {1'b0, kept} + (MAN_W+1)'(round_up);
        carry    = sum[MAN_W];
        man_o    = sum[MAN_W-1:0];
        exp_o    = $signed(XW'(exp_a_i)) + $signed(XW'(exp_b_i))
                 - $signed(XW'(BIAS)) + $signed(XW'(top)) + $signed(XW'(carry));
    end
endmodule

// File: rtl/fp24_mul.sv
module fp24_mul
    import fp24_pkg::*;
#(
    parameter int EXP_W = 7,
    parameter int MAN_W = 16,
    localparam int W    = 1 + EXP_W + MAN_W,
    localparam int XW   = EXP_W + 3,
    localparam int EMAX = (1 << EXP_W) - 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    output logic         out_valid,
    output logic [W-1:0] out_prod
);
    localparam logic [W-1:0] CANON_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

    typedef struct packed {
        logic         vld;
        logic [W-1:0] prod;
    } state_t;

    state_t state_d, state_q;

    logic [W-1:0]     opnd [2];
    fp_class_e        cls  [2];
    logic             sgn  [2];
    logic [EXP_W-1:0] ex   [2];
    logic [MAN_W-1:0] mn   [2];

    assign opnd[0] = in_a;
    assign opnd[1] = in_b;

    for (genvar g = 0; g < 2; g++) begin : g_unpack
        fp24_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) unpack_i (
            .word_i (opnd[g]),
            .cls_o  (cls[g]),
            .sign_o (sgn[g]),
            .exp_o  (ex[g]),
            .man_o  (mn[g])
        );
    end

    logic signed [XW-1:0] res_exp;
    logic [MAN_W-1:0]     res_man;

    fp24_sigmul #(.EXP_W(EXP_W), .MAN_W(MAN_W)) sigmul_i (
        .exp_a_i (ex[0]),
        .exp_b_i (ex[1]),
        .man_a_i (mn[0]),
        .man_b_i (mn[1]),
        .exp_o   (res_exp),
        .man_o   (res_man)
    );

    logic any_nan, any_zero, any_inf, ovf, unf, psign;

    always_comb begin
        any_nan  = (cls[0] == CLS_NAN)  || (cls[1] == CLS_NAN);
        any_zero = (cls[0] == CLS_ZERO) || (cls[1] == CLS_ZERO);
        any_inf  = (cls[0] == CLS_INF)  || (cls[1] == CLS_INF);
        psign    = sgn[0] ^ sgn[1];
        ovf      = res_exp >= $signed(XW'(EMAX));
        unf      = res_exp < $signed(XW'(0));

        state_d     = state_q;
        state_d.vld = in_valid;
        if (in_valid) begin
            if (any_nan) begin
                state_d.prod = CANON_NAN;
            end else if (any_zero || (!any_inf && unf)) begin
                state_d.prod = '0;
            end else if (any_inf || ovf) begin
                state_d.prod = {psign, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
            end else begin
                state_d.prod = {psign, res_exp[EXP_W-1:0], res_man};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.vld;
    assign out_prod  = state_q.prod;

    // Port-level views used by the properties below
    logic a_nan, b_nan, a_inf, b_inf;
    assign a_nan = (&in_a[W-2 -: EXP_W]) && (in_a[MAN_W-1:0] != '0);
    assign b_nan = (&in_b[W-2 -: EXP_W]) && (in_b[MAN_W-1:0] != '0);
    assign a_inf = (&in_a[W-2 -: EXP_W]) && (in_a[MAN_W-1:0] == '0);
    assign b_inf = (&in_b[W-2 -: EXP_W]) && (in_b[MAN_W-1:0] == '0);

    assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_prod));
    assert_nan_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (a_nan || b_nan) |=> out_prod == CANON_NAN);
    assert_no_stray_nan_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (&out_prod[W-2 -: EXP_W]) |->
            (out_prod[MAN_W-1:0] == '0) || (out_prod == CANON_NAN));
    assert_zero_times_inf_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && ((in_a == '0 && b_inf) || (in_b == '0 && a_inf)) |=> out_prod == '0);
    assert_zero_operand_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (in_a == '0 || in_b == '0) && !a_nan && !b_nan |=> out_prod == '0);
    assert_inf_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && a_inf && in_b != '0 && !b_nan |=>
            out_prod == {$past(in_a[W-1] ^ in_b[W-1]), {EXP_W{1'b1}}, {MAN_W{1'b0}}});
endmodule

// File: tb/fp24_mul_tb_top.sv
`timescale 1ns/1ps
module fp24_mul_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [23:0] in_a = '0;
    logic [23:0] in_b = '0;
    logic        out_valid;
    logic [23:0] out_prod;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    fp24_mul dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_prod(out_prod)
    );

    // Independent model written from the requirements
    function automatic logic [23:0] ref_mul(input logic [23:0] a, input logic [23:0] b);
        int     ea, eb, e, sh;
        longint p, q, r, half;
        logic   s, na, nb, ia, ib;
        ea = int'(a[22:16]);
        eb = int'(b[22:16]);
        na = (ea == 127) && (a[15:0] != 0);
        nb = (eb == 127) && (b[15:0] != 0);
        ia = (ea == 127) && (a[15:0] == 0);
        ib = (eb == 127) && (b[15:0] == 0);
        s  = a[23] ^ b[23];
        if (na || nb) return 24'h7F8000;
        if (a == 0 || b == 0) return 24'h000000;
        if (ia || ib) return {s, 7'h7F, 16'h0};
        p = (longint'(65536) + longint'(a[15:0])) * (longint'(65536) + longint'(b[15:0]));
        e = ea + eb - 63;
        if (p >= (longint'(1) << 33)) begin
            sh = 17;
            e  = e + 1;
        end else begin
            sh = 16;
        end
        q    = p >> sh;
        r    = p - (q << sh);
        half = longint'(1) << (sh - 1);
        if (r > half || (r == half && q[0])) q = q + 1;
        if (q == (longint'(1) << 17)) begin
            q = longint'(1) << 16;
            e = e + 1;
        end
        if (e > 126) return {s, 7'h7F, 16'h0};
        if (e < 0) return 24'h000000;
        return {s, 7'(e), q[15:0]};
    endfunction

    task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %06h expected %06h", tag, act, exp);
        end
    endtask

    task automatic run_op(input string tag, input logic [23:0] a, input logic [23:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_a     = a;
        in_b     = b;
        @(negedge clk);
        check({tag, " valid"}, {23'h0, out_valid}, 24'h1);
        check(tag, out_prod, ref_mul(a, b));
    endtask

    function automatic logic [23:0] rand_operand();
        int unsigned k;
        logic [15:0] m;
        k = $urandom % 16;
        m = 16'($urandom);
        case (k)
            0: return 24'h000000;
            1: return {1'($urandom), 7'h7F, 16'h0};
            2: return {1'($urandom), 7'h7F, (m == 0) ? 16'h0001 : m};
            3: return {1'($urandom), 7'($urandom % 127), m};
            default: return {1'($urandom), 7'(43 + $urandom % 41), m};
        endcase
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [23:0] held;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 reset valid", {23'h0, out_valid}, 24'h0);
        check("R10 reset prod", out_prod, 24'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R6 plain products
        run_op("R6 one*one", 24'h3F0000, 24'h3F0000);
        check("R6 one*one exact", out_prod, 24'h3F0000);
        run_op("R6 1.5*1.5", 24'h3F8000, 24'h3F8000);
        check("R6 1.5*1.5 exact", out_prod, 24'h402000);
        run_op("R6 -2*3", 24'hC00000, 24'h408000);
        check("R6 -2*3 exact", out_prod, 24'hC18000);
        // R1 sign-only word is a number, not zero
        run_op("R1 0x800000*one", 24'h800000, 24'h3F0000);
        check("R1 0x800000*one exact", out_prod, 24'h800000);
        // R7 rounding
        run_op("R7 tie up to even", 24'h3F0001, 24'h3F8000);
        check("R7 tie up exact", out_prod, 24'h3F8002);
        run_op("R7 tie stays even", 24'h3F0003, 24'h3F8000);
        check("R7 tie stays exact", out_prod, 24'h3F8004);
        run_op("R7 carry", 24'h3FFFFF, 24'h3F0001);
        run_op("R7 max frac", 24'h3FFFFF, 24'h3FFFFF);
        // R8 / R9 limits
        run_op("R8 overflow", 24'h7E0000, 24'h7E0000);
        check("R8 overflow exact", out_prod, 24'h7F0000);
        run_op("R8 neg overflow", 24'hFE0000, 24'h7E0000);
        check("R8 neg overflow exact", out_prod, 24'hFF0000);
        run_op("R8 exact max", 24'h3F0000, 24'h7E0000);
        check("R8 exact max value", out_prod, 24'h7E0000);
        run_op("R9 underflow", 24'h010000, 24'h810000);
        check("R9 underflow exact", out_prod, 24'h000000);
        // R2 / R3 / R4 / R5 specials
        run_op("R2 zero*neg", 24'h000000, 24'hC18000);
        check("R2 zero*neg exact", out_prod, 24'h000000);
        run_op("R3 zero*inf", 24'h000000, 24'h7F0000);
        check("R3 zero*inf exact", out_prod, 24'h000000);
        run_op("R3 -inf*zero", 24'hFF0000, 24'h000000);
        check("R3 -inf*zero exact", out_prod, 24'h000000);
        run_op("R4 nan*zero", 24'h7F0001, 24'h000000);
        check("R4 nan*zero exact", out_prod, 24'h7F8000);
        run_op("R4 inf*nan", 24'h7F0000, 24'hFFFFFF);
        run_op("R5 -inf*inf", 24'hFF0000, 24'h7F0000);
        check("R5 -inf*inf exact", out_prod, 24'hFF0000);
        run_op("R5 inf*-small", 24'h7F0000, 24'h810000);

        // R10 idle cycle: valid drops, product held
        held = out_prod;
        @(negedge clk);
        in_valid = 1'b0;
        in_a     = 24'h3F8000;
        in_b     = 24'h408000;
        @(negedge clk);
        check("R10 idle valid", {23'h0, out_valid}, 24'h0);
        check("R10 idle hold", out_prod, held);

        // R6 R7 R8 R9 random mix
        for (int i = 0; i < 3000; i++) begin
            run_op("R6 random", rand_operand(), rand_operand());
        end

        @(negedge clk);
        in_valid = 1'b0;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule